// File: doc/BRIEF.md
# Multi-field bitmap intersection rule classifier

This block sorts a packet header into one of a small set of rules. The header carries several fields of equal width. A packet matches a rule only when every field falls inside that rule's condition for the field. The block does not compare rules one at a time. Each field has its own lookup unit, and that unit returns a vector with one bit per rule, set where the rule covers the field's value. The vectors of all fields are ANDed together. A priority encoder then picks the lowest-numbered surviving rule, because index 0 has the highest priority.

Rules are loaded one field at a time through a write port. Each write names the rule, the field, a condition kind and two operands. A compiler stage turns that condition into an inclusive pair of bounds, low and high, and stores the pair. Prefix conditions, exact values and numeric ranges therefore all reduce to the same comparison hardware.

A header strobe starts a classification, and the result appears two cycles later. Writes are held off while a header is being looked up, so a result always reflects one consistent table.

Top module: `rule_classifier`

## Requirements
- R1: After reset every rule is empty and the outputs `res_valid`, `res_rule_id` and `res_no_match` are 0. A header classified before any write reports `res_no_match` = 1.
- R2: Kind code 0 (exact) matches only the field value equal to `wr_value`.
- R3: Kind code 1 (range) matches field values from `wr_value` to `wr_arg`, both ends included. When `wr_value` > `wr_arg` the field, and so the rule, never matches.
- R4: Kind code 2 (prefix) matches values whose top L bits equal those of `wr_value`, where L = `wr_arg` low bits. L = 0 matches any value, and an L larger than the field width is treated as the full width, which acts as an exact match.
- R5: A rule matches only when all fields match. A mismatch in any single field removes the rule.
- R6: When several rules match, `res_rule_id` is the lowest matching index.
- R7: When no rule matches, `res_no_match` = 1 and `res_rule_id` = 0.
- R8: `res_valid` pulses for one cycle exactly two clock edges after each cycle with `hdr_valid` high. Headers on consecutive cycles each give their own result, on consecutive cycles.
- R9: `wr_ready` is low while `hdr_valid` is high and during the cycle after it. A write offered while `wr_ready` is low leaves the table unchanged.
- R10: A write with kind code 3 leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header strobe that starts one classification |
| hdr_fields | input | NUM_FIELDS*FIELD_W | Header fields; field d sits at bits [d*FIELD_W +: FIELD_W] |
| wr_en | input | 1 | Rule field write request |
| wr_rule | input | clog2(NUM_RULES) | Rule index to write |
| wr_field | input | max(1,clog2(NUM_FIELDS)) | Field index to write |
| wr_kind | input | 2 | 0 exact, 1 range, 2 prefix, 3 ignored |
| wr_value | input | FIELD_W | Exact value, range low bound, or prefix value |
| wr_arg | input | FIELD_W | Range high bound, or prefix length |
| wr_ready | output | 1 | A write is accepted on an edge where this is high |
| res_valid | output | 1 | One-cycle result strobe |
| res_rule_id | output | clog2(NUM_RULES) | Winning rule index |
| res_no_match | output | 1 | No rule matched |

## Verification
The bench builds the block with its defaults: three 8-bit fields and 16 rules. With 8-bit fields, a prefix length of 9 tests the clamp to the full width, and a range from 0 to 255 spans the whole field. With 16 rules, a rule at index 15, the lowest priority, can be checked alongside overlapping rules at low indices. Most rules stay empty, so the reset state of the table can still be seen through the ports after programming.

// File: rtl/clsf_pkg.sv
package clsf_pkg;
   typedef enum logic [1:0] {
      KIND_EXACT  = 2'd0,
      KIND_RANGE  = 2'd1,
      KIND_PREFIX = 2'd2,
      KIND_RSVD   = 2'd3
   } rule_kind_e;
endpackage

// File: rtl/clsf_bound_gen.sv
module clsf_bound_gen
   import clsf_pkg::*;
#(
   parameter int FIELD_W = 8
) (
   input  rule_kind_e           kind,
   input  logic [FIELD_W-1:0]   value,
   input  logic [FIELD_W-1:0]   arg,
   output logic [FIELD_W-1:0]   lo,
   output logic [FIELD_W-1:0]   hi,
   output logic                 legal
);
   localparam int LEN_W = $clog2(FIELD_W + 1);

   logic [LEN_W-1:0]   len_raw;
   int                 len_c;
   logic [FIELD_W-1:0] keep;

   assign len_raw = arg[LEN_W-1:0];

   always_comb begin
      len_c = (int'(len_raw) > FIELD_W) ? FIELD_W : int'(len_raw);
      keep  = '0;
      for (int i = 0; i < FIELD_W; i++) begin
         keep[i] = (i >= FIELD_W - len_c);
      end
   end

   always_comb begin
      lo    = value;
      hi    = value;
      legal = 1'b1;
      case (kind)
         KIND_EXACT: begin
            lo = value;
            hi = value;
         end
         KIND_RANGE: begin
            lo = value;
            hi = arg;
         end
         KIND_PREFIX: begin
            lo = value & keep;
            hi = value | ~keep;
         end
         default: legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/clsf_dim_lookup.sv
module clsf_dim_lookup #(
   parameter int FIELD_W   = 8,
   parameter int NUM_RULES = 16,
   localparam int RID_W    = $clog2(NUM_RULES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_go,
   input  logic [RID_W-1:0]     wr_rule,
   input  logic [FIELD_W-1:0]   wr_lo,
   input  logic [FIELD_W-1:0]   wr_hi,
   input  logic                 look_en,
   input  logic [FIELD_W-1:0]   look_val,
   output logic [NUM_RULES-1:0] hit_vec
);
   logic [NUM_RULES-1:0][FIELD_W-1:0] lo_q;
   logic [NUM_RULES-1:0][FIELD_W-1:0] hi_q;

   for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q[r] <= '1;
            hi_q[r] <= '0;
         end else if (wr_go && wr_rule == RID_W'(r)) begin
            lo_q[r] <= wr_lo;
            hi_q[r] <= wr_hi;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       hit_vec[r] <= 1'b0;
         else if (look_en) hit_vec[r] <= (look_val >= lo_q[r]) && (look_val <= hi_q[r]);
      end

      // R3: an inverted bound pair must never report a hit
      p_empty_never_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(hit_vec[r]) |-> $past(lo_q[r] <= hi_q[r]));
   end

   // R9: the table is frozen in the edge after a lookup starts
   p_table_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      look_en |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/clsf_prio_enc.sv
module clsf_prio_enc #(
   parameter int NUM_RULES = 16,
   localparam int RID_W    = $clog2(NUM_RULES)
) (
   input  logic                 chk_en,
   input  logic [NUM_RULES-1:0] vec,
   output logic [RID_W-1:0]     idx,
   output logic                 any
);
   always_comb begin
      idx = '0;
      any = |vec;
      for (int i = NUM_RULES - 1; i >= 0; i--) begin
         if (vec[i]) idx = RID_W'(i);
      end
   end

   logic [NUM_RULES-1:0] below;
   always_comb begin
      below = '0;
      for (int i = 0; i < NUM_RULES; i++) begin
         below[i] = (i < int'(idx));
      end
   end

   // R6: the chosen bit is set and nothing below it is set
   always_comb begin
      if (chk_en && any) begin
         p_lowest_wins_r6: assert (vec[idx] && ((vec & below) == '0));
      end
   end
endmodule

// File: rtl/rule_classifier.sv
module rule_classifier
   import clsf_pkg::*;
#(
   parameter int NUM_FIELDS = 3,
   parameter int FIELD_W    = 8,
   parameter int NUM_RULES  = 16,
   localparam int RID_W     = $clog2(NUM_RULES),
   localparam int FID_W     = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
   localparam int HDR_W     = NUM_FIELDS * FIELD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hdr_valid,
   input  logic [HDR_W-1:0]   hdr_fields,
   input  logic               wr_en,
   input  logic [RID_W-1:0]   wr_rule,
   input  logic [FID_W-1:0]   wr_field,
   input  logic [1:0]         wr_kind,
   input  logic [FIELD_W-1:0] wr_value,
   input  logic [FIELD_W-1:0] wr_arg,
   output logic               wr_ready,
   output logic               res_valid,
   output logic [RID_W-1:0]   res_rule_id,
   output logic               res_no_match
);
   if (NUM_FIELDS < 1) begin : g_bad_fields
      $error("NUM_FIELDS must be at least 1");
   end
   if (FIELD_W < 2) begin : g_bad_width
      $error("FIELD_W must be at least 2");
   end
   if (NUM_RULES < 2) begin : g_bad_rules
      $error("NUM_RULES must be at least 2");
   end

   logic               s1_valid;
   logic               wr_legal;
   logic               wr_go;
   logic [FIELD_W-1:0] wr_lo;
   logic [FIELD_W-1:0] wr_hi;

   assign wr_ready = !(hdr_valid || s1_valid);

   clsf_bound_gen #(.FIELD_W(FIELD_W)) u_bounds (
      .kind  (rule_kind_e'(wr_kind)),
      .value (wr_value),
      .arg   (wr_arg),
      .lo    (wr_lo),
      .hi    (wr_hi),
      .legal (wr_legal)
   );

   assign wr_go = wr_en && wr_ready && wr_legal;

   logic [NUM_FIELDS-1:0][NUM_RULES-1:0] dim_vec;

   for (genvar d = 0; d < NUM_FIELDS; d++) begin : g_dim
      clsf_dim_lookup #(.FIELD_W(FIELD_W), .NUM_RULES(NUM_RULES)) u_dim (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_go    (wr_go && wr_field == FID_W'(d)),
         .wr_rule  (wr_rule),
         .wr_lo    (wr_lo),
         .wr_hi    (wr_hi),
         .look_en  (hdr_valid),
         .look_val (hdr_fields[d*FIELD_W +: FIELD_W]),
         .hit_vec  (dim_vec[d])
      );
   end

   logic [NUM_RULES-1:0] cand;
   always_comb begin
      cand = '1;
      for (int d = 0; d < NUM_FIELDS; d++) begin
         cand = cand & dim_vec[d];
      end
   end

   logic [RID_W-1:0] win_idx;
   logic             win_any;

   clsf_prio_enc #(.NUM_RULES(NUM_RULES)) u_prio (
      .chk_en (s1_valid),
      .vec    (cand),
      .idx    (win_idx),
      .any    (win_any)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid     <= 1'b0;
         res_valid    <= 1'b0;
         res_rule_id  <= '0;
         res_no_match <= 1'b0;
      end else begin
         s1_valid  <= hdr_valid;
         res_valid <= s1_valid;
         if (s1_valid) begin
            res_rule_id  <= win_any ? win_idx : '0;
            res_no_match <= !win_any;
         end
      end
   end

   // R8: every header gets a result two edges later
   p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |-> ##2 res_valid);

   // R8: no result without a header two edges earlier
   p_no_orphan_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(hdr_valid, 2));

   // R7: a miss reports index zero
   p_miss_zero_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_no_match) |-> (res_rule_id == '0));

   // R9: the port refuses writes while a header is being taken
   p_ready_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |-> !wr_ready);
endmodule

// File: tb/tb_rule_classifier.sv
`timescale 1ns/1ps
module tb_rule_classifier;
   localparam int NF = 3;
   localparam int FW = 8;
   localparam int NR = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          hdr_valid;
   logic [23:0]   hdr_fields;
   logic          wr_en;
   logic [3:0]    wr_rule;
   logic [1:0]    wr_field;
   logic [1:0]    wr_kind;
   logic [7:0]    wr_value;
   logic [7:0]    wr_arg;
   logic          wr_ready;
   logic          res_valid;
   logic [3:0]    res_rule_id;
   logic          res_no_match;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   rule_classifier #(.NUM_FIELDS(NF), .FIELD_W(FW), .NUM_RULES(NR)) dut (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_fields(hdr_fields),
      .wr_en(wr_en), .wr_rule(wr_rule), .wr_field(wr_field), .wr_kind(wr_kind),
      .wr_value(wr_value), .wr_arg(wr_arg), .wr_ready(wr_ready),
      .res_valid(res_valid), .res_rule_id(res_rule_id), .res_no_match(res_no_match)
   );

   // f0, f1, f2, expected no_match, expected id
   localparam int VECS [0:14][0:4] = '{
      '{10,  25, 'hA5, 0, 0},   // R2 R3 R4 R6
      '{10,  25, 'h00, 0, 4},   // R6
      '{10,  20, 'hAF, 0, 0},   // R3 low edge
      '{10,  30, 'hA0, 0, 0},   // R3 high edge
      '{10,  31, 'hA0, 1, 0},   // R3 R7
      '{11,  25, 'hA5, 1, 0},   // R2 R5
      '{10,  25, 'h55, 0, 1},   // R6
      '{'h99,'h99,'h55, 0, 1},  // R4 wildcard
      '{'h40, 7,  75,  1, 0},   // R3 empty range
      '{'h80, 9,  9,   0, 3},   // R4 clamp
      '{'h81, 9,  9,   1, 0},   // R4 clamp
      '{205, 200, 210, 0, 15},  // R3
      '{205, 200, 211, 1, 0},   // R5
      '{'h80, 0, 'h55, 0, 1},   // R6
      '{10,  19, 'hA5, 1, 0}    // R5 R7
   };

   task automatic chk(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_rule(int rule, int field, int kind, int value, int arg);
      @(negedge clk);
      wr_en    = 1'b1;
      wr_rule  = 4'(rule);
      wr_field = 2'(field);
      wr_kind  = 2'(kind);
      wr_value = 8'(value);
      wr_arg   = 8'(arg);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic classify(string req, int f0, int f1, int f2, int exp_nm, int exp_id);
      @(negedge clk);
      hdr_valid  = 1'b1;
      hdr_fields = {8'(f2), 8'(f1), 8'(f0)};
      @(negedge clk);
      hdr_valid = 1'b0;
      @(negedge clk);
      chk({req, " valid"}, int'(res_valid), 1);
      chk({req, " no_match"}, int'(res_no_match), exp_nm);
      chk({req, " rule_id"}, int'(res_rule_id), exp_id);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; hdr_valid = 1'b0; hdr_fields = '0;
      wr_en = 1'b0; wr_rule = '0; wr_field = '0; wr_kind = '0;
      wr_value = '0; wr_arg = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 res_valid", int'(res_valid), 0);
      chk("R1 rule_id", int'(res_rule_id), 0);
      chk("R1 no_match", int'(res_no_match), 0);
      chk("R9 ready idle", int'(wr_ready), 1);
      classify("R1 empty table", 0, 0, 0, 1, 0);

      // program rules: kinds 0 exact, 1 range, 2 prefix
      write_rule(0, 0, 0, 10, 0);
      write_rule(0, 1, 1, 20, 30);
      write_rule(0, 2, 2, 'hA0, 4);
      write_rule(1, 0, 1, 0, 255);
      write_rule(1, 1, 2, 0, 0);
      write_rule(1, 2, 0, 'h55, 0);
      write_rule(2, 0, 2, 'h40, 2);
      write_rule(2, 1, 0, 7, 0);
      write_rule(2, 2, 1, 100, 50);
      write_rule(3, 0, 2, 'h80, 9);
      write_rule(3, 1, 2, 0, 0);
      write_rule(3, 2, 2, 0, 0);
      write_rule(4, 0, 0, 10, 0);
      write_rule(4, 1, 1, 20, 30);
      write_rule(4, 2, 2, 0, 0);
      write_rule(15, 0, 1, 200, 210);
      write_rule(15, 1, 1, 200, 210);
      write_rule(15, 2, 1, 200, 210);

      for (int i = 0; i < 15; i++) begin
         classify($sformatf("R5 vec%0d", i), VECS[i][0], VECS[i][1], VECS[i][2],
                  VECS[i][3], VECS[i][4]);
      end

      // R10: kind 3 write to rule 3 field 0 is ignored
      write_rule(3, 0, 3, 0, 0);
      classify("R10 kind3 ignored", 'h80, 1, 1, 0, 3);

      // R8 latency and single pulse
      @(negedge clk);
      hdr_valid = 1'b1; hdr_fields = {8'hA5, 8'd25, 8'd10};
      @(negedge clk);
      hdr_valid = 1'b0;
      chk("R8 not yet", int'(res_valid), 0);
      chk("R9 ready low in flight", int'(wr_ready), 0);
      @(negedge clk);
      chk("R8 valid at 2", int'(res_valid), 1);
      @(negedge clk);
      chk("R8 single pulse", int'(res_valid), 0);

      // R8 back to back
      @(negedge clk);
      hdr_valid = 1'b1; hdr_fields = {8'd210, 8'd200, 8'd205};
      @(negedge clk);
      hdr_fields = {8'h55, 8'd25, 8'd10};
      @(negedge clk);
      hdr_valid = 1'b0;
      chk("R8 b2b first valid", int'(res_valid), 1);
      chk("R8 b2b first id", int'(res_rule_id), 15);
      @(negedge clk);
      chk("R8 b2b second valid", int'(res_valid), 1);
      chk("R8 b2b second id", int'(res_rule_id), 1);

      // R9: write offered during a header is dropped
      @(negedge clk);
      hdr_valid = 1'b1; hdr_fields = {8'd1, 8'd1, 8'h80};
      wr_en = 1'b1; wr_rule = 4'd3; wr_field = 2'd0; wr_kind = 2'd0;
      wr_value = 8'h81; wr_arg = 8'd0;
      #1;
      chk("R9 ready low with header", int'(wr_ready), 0);
      @(negedge clk);
      hdr_valid = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R9 held result id", int'(res_rule_id), 3);
      classify("R9 table unchanged", 'h80, 1, 1, 0, 3);
      classify("R9 no stray write", 'h81, 1, 1, 1, 0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule